// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This execution unit rearranges the bytes of 64-bit data under control of a stored selector word. It holds one 64-bit control register. Its upper half holds eight 4-bit lane selectors. It performs two operations, chosen by a one-bit opcode.

The mask operation adds its two operands and returns the full 64-bit sum. As a side effect, it loads the low 32 bits of that sum into the selector half of the control register. The shuffle operation treats its two operands as a 16-byte pool. It fills each of the eight result bytes with whichever pool byte that lane's selector names.

A feature-enable input can disable both operations; an operation issued while it is low is reported as illegal. A separate port loads the whole control register at once, and that load wins over a mask operation issued in the same cycle. All results are registered.

Top module: `bytesel_unit`

## Requirements
- R1: In the first cycle after synchronous reset, before any operation, `res_o`, `res_valid_o`, `illegal_o` and `ctl_o` are all zero.
- R2: A mask operation (`op_sel_i` = 0) with `feat_en_i` high returns `opa_i + opb_i` modulo 2^64 on `res_o`, one cycle after issue.
- R3: A legal mask operation sets `ctl_o[63:32]` to the low 32 bits of the sum and keeps `ctl_o[31:0]` unchanged, visible from the next cycle.
- R4: For a shuffle operation (`op_sel_i` = 1), the pool bytes 0..7 are `opa_i` from its most significant byte down, and pool bytes 8..15 are `opb_i` the same way. Result byte i (i = 0 is bits 63:56) equals the pool byte indexed by `ctl_o[63-4i:60-4i]`.
- R5: Selectors may repeat or appear in any order. With the reset value of zero, a shuffle copies the top byte of `opa_i` into all eight result bytes.
- R6: A shuffle issued in the cycle right after a mask operation uses the selector word that mask operation wrote.
- R7: An operation issued while `feat_en_i` is low raises `illegal_o` for exactly one cycle, one cycle after issue. It does not raise `res_valid_o`, and it changes neither `res_o` nor `ctl_o`.
- R8: When `ctl_wr_i` is high, `ctl_o` takes all 64 bits of `ctl_wr_data_i` in the next cycle, even if a mask operation is issued in the same cycle. That mask operation still returns its sum, and a shuffle issued in that cycle uses the old selector word.
- R9: `res_valid_o` is high for exactly one cycle, one cycle after each legal operation, and is low otherwise. It is never high together with `illegal_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation strobe |
| op_sel_i | input | 1 | 0 = mask, 1 = shuffle |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| feat_en_i | input | 1 | Operations allowed when high |
| ctl_wr_i | input | 1 | Full control register load strobe |
| ctl_wr_data_i | input | 64 | Value for full load |
| res_o | output | 64 | Registered result |
| res_valid_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Disabled-operation pulse |
| ctl_o | output | 64 | Control register contents |

## Verification
Two things can land in the same cycle: a full load of the control register and an operation, either a mask operation or a shuffle. The bench issues a mask operation together with a full load and checks two things. The sum still appears on the result. The register then holds the full-load value, with no trace of the sum. It also issues a shuffle together with a full load and expects the result to follow the selector word from before the load. A shuffle placed directly after a mask operation confirms that the newly written selectors take effect in the very next cycle.

// File: rtl/bytesel_pkg.sv
package bytesel_pkg;

    parameter int DATA_W = 64;
    parameter int LANE_W = 8;

    typedef enum logic {
        OP_MASK = 1'b0,
        OP_SHUF = 1'b1
    } op_e;

    typedef struct packed {
        logic run;
        logic trap;
        logic do_mask;
        logic do_shuf;
    } dec_t;

    function automatic dec_t decode(input logic vld, input logic en, input op_e op);
        dec_t d;
        d.run     = vld & en;
        d.trap    = vld & ~en;
        d.do_mask = d.run & (op == OP_MASK);
        d.do_shuf = d.run & (op == OP_SHUF);
        return d;
    endfunction

endpackage

// File: rtl/bytesel_ctlreg.sv
module bytesel_ctlreg #(
    parameter int DW    = 64,
    parameter int MSK_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             mask_en,
    input  logic [MSK_W-1:0] mask_val,
    output logic [DW-1:0]    q
);
    localparam int KEEP_W = DW - MSK_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr_en) begin
            q <= wr_data;
        end else if (mask_en) begin
            q <= {mask_val, q[KEEP_W-1:0]};
        end
    end
endmodule

// File: rtl/bytesel_permute.sv
module bytesel_permute #(
    parameter int DW = 64,
    parameter int LW = 8
) (
    input  logic [DW-1:0]                         src_hi,
    input  logic [DW-1:0]                         src_lo,
    input  logic [(DW/LW)*$clog2(2*(DW/LW))-1:0]  sel,
    output logic [DW-1:0]                         dout
);
    localparam int LANES = DW / LW;
    localparam int POOL  = 2 * LANES;
    localparam int SEL_W = $clog2(POOL);
    localparam int MSK_W = LANES * SEL_W;

    logic [LW-1:0] pool [POOL];

    for (genvar k = 0; k < POOL; k++) begin : g_pool
        if (k < LANES) begin : g_hi
            assign pool[k] = src_hi[DW-1-k*LW -: LW];
        end else begin : g_lo
            assign pool[k] = src_lo[DW-1-(k-LANES)*LW -: LW];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [SEL_W-1:0] nib;
        assign nib = sel[MSK_W-1-i*SEL_W -: SEL_W];
        assign dout[DW-1-i*LW -: LW] = pool[nib];
    end
endmodule

// File: rtl/bytesel_unit.sv
module bytesel_unit
    import bytesel_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int LW = LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid_i,
    input  logic          op_sel_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic          feat_en_i,
    input  logic          ctl_wr_i,
    input  logic [DW-1:0] ctl_wr_data_i,
    output logic [DW-1:0] res_o,
    output logic          res_valid_o,
    output logic          illegal_o,
    output logic [DW-1:0] ctl_o
);
    localparam int LANES = DW / LW;
    localparam int SEL_W = $clog2(2 * LANES);
    localparam int MSK_W = LANES * SEL_W;

    dec_t          dec;
    logic [DW-1:0] sum;
    logic [DW-1:0] shuf;

    assign dec = decode(op_valid_i, feat_en_i, op_e'(op_sel_i));
    assign sum = opa_i + opb_i;

    bytesel_ctlreg #(.DW(DW), .MSK_W(MSK_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctl_wr_i),
        .wr_data  (ctl_wr_data_i),
        .mask_en  (dec.do_mask),
        .mask_val (sum[MSK_W-1:0]),
        .q        (ctl_o)
    );

    bytesel_permute #(.DW(DW), .LW(LW)) u_perm (
        .src_hi (opa_i),
        .src_lo (opb_i),
        .sel    (ctl_o[DW-1 -: MSK_W]),
        .dout   (shuf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o       <= '0;
            res_valid_o <= 1'b0;
            illegal_o   <= 1'b0;
        end else begin
            res_valid_o <= dec.run;
            illegal_o   <= dec.trap;
            if (dec.run) begin
                res_o <= dec.do_shuf ? shuf : sum;
            end
        end
    end
endmodule

// File: rtl/bytesel_chk.sv
module bytesel_chk #(
    parameter int DW    = 64,
    parameter int MSK_W = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          op_valid_i,
    input logic          op_sel_i,
    input logic [DW-1:0] opa_i,
    input logic [DW-1:0] opb_i,
    input logic          feat_en_i,
    input logic          ctl_wr_i,
    input logic [DW-1:0] ctl_wr_data_i,
    input logic [DW-1:0] res_o,
    input logic          res_valid_o,
    input logic          illegal_o,
    input logic [DW-1:0] ctl_o
);
    localparam int KEEP_W = DW - MSK_W;

    p_sum_r2: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && feat_en_i && !op_sel_i) |=> (res_o == $past(opa_i + opb_i)));

    p_mask_load_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && feat_en_i && !op_sel_i && !ctl_wr_i) |=>
        (ctl_o[DW-1 -: MSK_W] == $past(opa_i[MSK_W-1:0] + opb_i[MSK_W-1:0]))
        && (ctl_o[KEEP_W-1:0] == $past(ctl_o[KEEP_W-1:0])));

    p_trap_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && !feat_en_i && !ctl_wr_i) |=>
        (illegal_o && !res_valid_o && $stable(res_o) && $stable(ctl_o)));

    p_full_load_r8: assert property (@(posedge clk) disable iff (rst)
        ctl_wr_i |=> (ctl_o == $past(ctl_wr_data_i)));

    p_valid_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid_i && feat_en_i) |=> res_valid_o);

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(op_valid_i && feat_en_i) |=> !res_valid_o);

    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(res_valid_o && illegal_o));
endmodule

bind bytesel_unit bytesel_chk #(.DW(DW), .MSK_W(MSK_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_valid_i    (op_valid_i),
    .op_sel_i      (op_sel_i),
    .opa_i         (opa_i),
    .opb_i         (opb_i),
    .feat_en_i     (feat_en_i),
    .ctl_wr_i      (ctl_wr_i),
    .ctl_wr_data_i (ctl_wr_data_i),
    .res_o         (res_o),
    .res_valid_o   (res_valid_o),
    .illegal_o     (illegal_o),
    .ctl_o         (ctl_o)
);

// File: tb/sim_bytesel_unit.sv
`timescale 1ns/1ps
module sim_bytesel_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid_i = 1'b0;
    logic        op_sel_i = 1'b0;
    logic [63:0] opa_i = '0;
    logic [63:0] opb_i = '0;
    logic        feat_en_i = 1'b1;
    logic        ctl_wr_i = 1'b0;
    logic [63:0] ctl_wr_data_i = '0;
    logic [63:0] res_o;
    logic        res_valid_o;
    logic        illegal_o;
    logic [63:0] ctl_o;

    always #10 clk = ~clk;

    bytesel_unit u0 (
        .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_sel_i(op_sel_i),
        .opa_i(opa_i), .opb_i(opb_i), .feat_en_i(feat_en_i), .ctl_wr_i(ctl_wr_i),
        .ctl_wr_data_i(ctl_wr_data_i), .res_o(res_o), .res_valid_o(res_valid_o),
        .illegal_o(illegal_o), .ctl_o(ctl_o)
    );

    typedef struct {
        bit          trap;
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [63:0] m_ctl = '0;
    logic [63:0] m_res = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_shuf(input logic [63:0] a, input logic [63:0] b,
                                                input logic [63:0] c);
        logic [127:0] cat;
        logic [63:0]  r;
        cat = {a, b};
        for (int i = 0; i < 8; i++) begin
            int n;
            n = int'(c[63-4*i -: 4]);
            r[63-8*i -: 8] = cat[127-8*n -: 8];
        end
        return r;
    endfunction

    task automatic issue(input bit op, input logic [63:0] a, input logic [63:0] b, input bit en,
                         input bit wr, input logic [63:0] wd, input string tag);
        exp_t        e;
        logic [63:0] s;
        @(negedge clk);
        op_valid_i = 1'b1; op_sel_i = op; opa_i = a; opb_i = b;
        feat_en_i = en; ctl_wr_i = wr; ctl_wr_data_i = wd;
        s = a + b;
        e.tag = tag;
        if (en) begin
            e.trap = 1'b0;
            e.data = op ? model_shuf(a, b, m_ctl) : s;
            m_res  = e.data;
        end else begin
            e.trap = 1'b1;
            e.data = m_res;
        end
        sb.push_back(e);
        if (wr) m_ctl = wd;
        else if (en && !op) m_ctl[63:32] = s[31:0];
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid_i = 1'b0; ctl_wr_i = 1'b0; feat_en_i = 1'b1;
    endtask

    task automatic load(input logic [63:0] wd);
        @(negedge clk);
        op_valid_i = 1'b0; ctl_wr_i = 1'b1; ctl_wr_data_i = wd;
        m_ctl = wd;
    endtask

    task automatic check_ctl(input string tag);
        idle();
        #1;
        chk(ctl_o === m_ctl, tag, ctl_o, m_ctl);
    endtask

    // Monitor: pops the scoreboard whenever the design reports an outcome
    always begin
        @(negedge clk);
        #1;
        if (!rst && (res_valid_o || illegal_o)) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R9 unexpected output", {63'd0, res_valid_o}, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(res_o === e.data, e.tag, res_o, e.data);
                chk(illegal_o === e.trap, {e.tag, " flag"}, {63'd0, illegal_o}, {63'd0, e.trap});
                chk(res_valid_o === !e.trap, {"R9 valid ", e.tag}, {63'd0, res_valid_o}, {63'd0, !e.trap});
            end
        end
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(res_o === 64'd0, "R1 res", res_o, 64'd0);
        chk(res_valid_o === 1'b0 && illegal_o === 1'b0, "R1 flags",
            {62'd0, res_valid_o, illegal_o}, 64'd0);
        chk(ctl_o === 64'd0, "R1 ctl", ctl_o, 64'd0);

        // R5: zero selectors replicate top byte of first operand
        issue(1'b1, 64'hA1B2C3D4E5F60718, 64'h1122334455667788, 1'b1, 1'b0, '0, "R5 reset mask");
        // R2: carry across the 32-bit boundary, selector half becomes zero
        issue(1'b0, 64'h00000000FFFFFFFF, 64'd1, 1'b1, 1'b0, '0, "R2 carry sum");
        issue(1'b0, 64'hFFFFFFFFFFFFFFFF, 64'd2, 1'b1, 1'b0, '0, "R2 wrap sum");
        check_ctl("R3 after sums");

        // R6/R4: identity on first operand, right after the mask op
        issue(1'b0, 64'h0000000001234000, 64'h567, 1'b1, 1'b0, '0, "R2 mask identity");
        issue(1'b1, 64'h0102030405060708, 64'h1112131415161718, 1'b1, 1'b0, '0, "R6 R4 identity a");
        issue(1'b0, 64'h0000000089ABCDEF, 64'd0, 1'b1, 1'b0, '0, "R2 mask b");
        issue(1'b1, 64'h0102030405060708, 64'h1112131415161718, 1'b1, 1'b0, '0, "R6 R4 identity b");
        issue(1'b0, 64'h00000000FEDCBA98, 64'd0, 1'b1, 1'b0, '0, "R2 mask reverse");
        issue(1'b1, 64'h0102030405060708, 64'h1112131415161718, 1'b1, 1'b0, '0, "R4 reverse b");
        issue(1'b0, 64'h000000000F0F0F0F, 64'd0, 1'b1, 1'b0, '0, "R2 mask dup");
        issue(1'b1, 64'hDEADBEEF00C0FFEE, 64'h0123456789ABCDEF, 1'b1, 1'b0, '0, "R5 duplicates");
        issue(1'b0, 64'h0000000030F7A85C, 64'd0, 1'b1, 1'b0, '0, "R2 mask mixed");
        issue(1'b1, 64'hDEADBEEF00C0FFEE, 64'h0123456789ABCDEF, 1'b1, 1'b0, '0, "R4 mixed");
        check_ctl("R3 selector half");

        // R8: full load, then R3 keeps the lower half
        load(64'hDEADBEEFCAFEF00D);
        check_ctl("R8 full load");
        issue(1'b0, 64'h0000000112345678, 64'h0000000100000001, 1'b1, 1'b0, '0, "R2 sum keep");
        check_ctl("R3 lower half kept");

        // R7: disabled operations
        issue(1'b0, 64'h5555, 64'h7777, 1'b0, 1'b0, '0, "R7 mask disabled");
        issue(1'b1, 64'h5555, 64'h7777, 1'b0, 1'b0, '0, "R7 shuffle disabled");
        check_ctl("R7 ctl unchanged");

        // R8: collisions with a full load
        issue(1'b0, 64'h0000000011111111, 64'h22222222, 1'b1, 1'b1, 64'h76543210FEDCBA98, "R8 mask with load");
        check_ctl("R8 load wins");
        issue(1'b1, 64'h0102030405060708, 64'h1112131415161718, 1'b1, 1'b1, 64'hFFFFFFFF00000000, "R8 shuffle old mask");
        check_ctl("R8 load after shuffle");
        issue(1'b1, 64'h0102030405060708, 64'h1112131415161718, 1'b1, 1'b0, '0, "R4 all last byte");

        repeat (4) idle();
        chk(sb.size() == 0, "R9 all results seen", 64'(sb.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule